// File: doc/BRIEF.md
# Dual-bus Manchester word encoder

This block turns 16-bit words from a host into serial bi-phase (Manchester) words on one of two differential bus pairs. Each word lasts 20 bit-times: a three-bit-time sync field, the 16 data bits sent most significant bit first, and one odd-parity bit. A mode input chooses the polarity of the sync field, which tells receivers whether the word is a command/status word or a data word. A channel-select input chooses the bus that carries the word.

The host side is a valid/ready stream into a single holding register. When the encoder is idle, a word written into the holding register starts on the next clock. While a word is being sent, one further word may be written. That word starts at the exact edge where the current word ends, so no gap appears between the two words. While the holding register is full, `wr_ready` stays low and the host must keep `wr_valid` and its data steady until the write is accepted. `send_ready` is high while a word is on the line and the holding register is empty. This is the window in which a write continues the message without a gap. Two disable inputs silence one bus pair each. The handshake and the timing go on unchanged while a pair is disabled.

With the default parameter a half bit-time is 25 clocks. At a 50 MHz clock this gives 1 Mbit/s.

Top module: `biphase_tx`

## Requirements
- R1: After reset all four bus outputs are low, `wr_ready` is 1 and `send_ready` is 0.
- R2: A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. If the encoder is idle, the word starts on the following edge. A word lasts 40 half-bit slots, numbered 0 to 39, and each slot lasts CLKS_PER_HALF clocks.
- R3: With `wr_cmd_sync`=1 the true output is high in slots 0-2 and low in slots 3-5. With `wr_cmd_sync`=0 these levels are inverted.
- R4: Data bit `wr_data[15-k]` occupies slots 6+2k and 7+2k. A 1 is sent high then low, and a 0 is sent low then high.
- R5: Slots 38 and 39 carry an odd-parity bit, coded like a data bit. The parity bit is 1 when `wr_data` holds an even number of ones.
- R6: On the active, enabled pair the complement output is the inverse of the true output. The pair that was not selected (`wr_chan_b`: 0 = bus A, 1 = bus B) stays with both outputs low.
- R7: While the holding register is full, `wr_ready` is 0 and no write is taken. A pending word waits until the current word ends.
- R8: `send_ready` is 1 exactly while a word is being sent and the holding register is empty. A word written in that window starts on the edge that ends the current word.
- R9: `dis_a` or `dis_b` holds its pair's two outputs low. It has no effect on the handshake, the timing or the other pair.
- R10: When a word ends and no word is pending, both outputs of every pair are low and `send_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host offers a word |
| wr_ready | output | 1 | Holding register can take a word |
| wr_data | input | 16 | Word to send |
| wr_chan_b | input | 1 | 0 selects bus A, 1 selects bus B |
| wr_cmd_sync | input | 1 | 1 selects the command/status sync, 0 the data sync |
| dis_a | input | 1 | Silence bus A pair |
| dis_b | input | 1 | Silence bus B pair |
| send_ready | output | 1 | Window for a gap-free next write |
| bus_a_p | output | 1 | Bus A true output |
| bus_a_n | output | 1 | Bus A complement output |
| bus_b_p | output | 1 | Bus B true output |
| bus_b_n | output | 1 | Bus B complement output |

## Verification
The hardest case to reach is a message of three words, where the third write is back-pressured and is accepted only on the edge where the second word leaves the holding register. The bench forks two processes. One samples every half-bit slot of three words in a row without breaking alignment. The other writes the second word inside the `send_ready` window and then at once offers the third word. If any slot is lost or duplicated at either word boundary, the patterns sampled for the second and third words will not match.

// File: rtl/biphase_pkg.sv
package biphase_pkg;
  localparam int DATA_W      = 16;
  localparam int SYNC_HALVES = 6;
  localparam int SLOTS       = SYNC_HALVES + 2 * (DATA_W + 1);
  localparam int SLOT_W      = $clog2(SLOTS);
  localparam int IDX_W       = $clog2(DATA_W + 1);
  localparam int NUM_BUS     = 2;

  typedef struct packed {
    logic              chan;
    logic              cmd;
    logic [DATA_W-1:0] data;
  } word_t;
endpackage

// File: rtl/biphase_seq.sv
module biphase_seq
  import biphase_pkg::*;
#(
  parameter int CLKS_PER_HALF = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  output logic              active,
  output logic [SLOT_W-1:0] slot,
  output logic              word_end
);
  localparam int CNT_W = (CLKS_PER_HALF > 1) ? $clog2(CLKS_PER_HALF) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(CLKS_PER_HALF - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  logic [CNT_W-1:0] half_cnt;
  logic             half_last;

  assign half_last = (half_cnt == CNT_LAST);
  assign word_end  = active && half_last && (slot == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      half_cnt <= '0;
      slot     <= '0;
    end else if (load) begin
      active   <= 1'b1;
      half_cnt <= '0;
      slot     <= '0;
    end else if (active) begin
      if (half_last) begin
        half_cnt <= '0;
        if (slot == SLOT_LAST) begin
          active <= 1'b0;
          slot   <= '0;
        end else begin
          slot <= slot + 1'b1;
        end
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/biphase_frame.sv
module biphase_frame
  import biphase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  word_t             wr_word,
  input  logic              active,
  input  logic              word_end,
  input  logic [SLOT_W-1:0] slot,
  output logic              wr_ready,
  output logic              load,
  output logic              cur_chan,
  output logic              level
);
  word_t             hold_q;
  word_t             cur_q;
  logic              hold_full;
  logic              wr_fire;
  logic [DATA_W:0]   seq;
  logic [SLOT_W-1:0] rel;
  logic [IDX_W-1:0]  idx;

  assign wr_ready = !hold_full;
  assign wr_fire  = wr_valid && wr_ready;
  assign load     = hold_full && (!active || word_end);
  assign cur_chan = cur_q.chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      cur_q     <= '0;
    end else begin
      if (load) begin
        hold_full <= 1'b0;
        cur_q     <= hold_q;
      end else if (wr_fire) begin
        hold_full <= 1'b1;
        hold_q    <= wr_word;
      end
    end
  end

  // Order of bits on the line after the sync field: data MSB first, then parity.
  always_comb begin
    for (int k = 0; k < DATA_W; k++) seq[k] = cur_q.data[DATA_W-1-k];
    seq[DATA_W] = ~^cur_q.data;
  end

  assign rel = slot - SLOT_W'(SYNC_HALVES);
  assign idx = IDX_W'(rel >> 1);

  always_comb begin
    if (slot < SLOT_W'(SYNC_HALVES))
      level = (slot < SLOT_W'(SYNC_HALVES / 2)) ~^ cur_q.cmd;
    else
      level = seq[idx] ^ rel[0];
  end
endmodule

// File: rtl/biphase_line.sv
module biphase_line
  import biphase_pkg::*;
(
  input  logic               active,
  input  logic               level,
  input  logic               chan,
  input  logic [NUM_BUS-1:0] dis,
  output logic [NUM_BUS-1:0] pos,
  output logic [NUM_BUS-1:0] neg
);
  for (genvar ch = 0; ch < NUM_BUS; ch++) begin : g_pair
    logic en;
    assign en      = active && (chan == 1'(ch)) && !dis[ch];
    assign pos[ch] = en & level;
    assign neg[ch] = en & ~level;
  end
endmodule

// File: rtl/biphase_tx.sv
module biphase_tx
  import biphase_pkg::*;
#(
  parameter int CLKS_PER_HALF = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_chan_b,
  input  logic              wr_cmd_sync,
  input  logic              dis_a,
  input  logic              dis_b,
  output logic              send_ready,
  output logic              bus_a_p,
  output logic              bus_a_n,
  output logic              bus_b_p,
  output logic              bus_b_n
);
  word_t              wr_word;
  logic               load;
  logic               active;
  logic               word_end;
  logic [SLOT_W-1:0]  slot;
  logic               cur_chan;
  logic               level;
  logic [NUM_BUS-1:0] pos;
  logic [NUM_BUS-1:0] neg;

  assign wr_word = '{chan: wr_chan_b, cmd: wr_cmd_sync, data: wr_data};

  biphase_seq #(.CLKS_PER_HALF(CLKS_PER_HALF)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load),
    .active(active), .slot(slot), .word_end(word_end)
  );

  biphase_frame u_frame (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .active(active), .word_end(word_end), .slot(slot),
    .wr_ready(wr_ready), .load(load), .cur_chan(cur_chan), .level(level)
  );

  biphase_line u_line (
    .active(active), .level(level), .chan(cur_chan),
    .dis({dis_b, dis_a}), .pos(pos), .neg(neg)
  );

  assign send_ready = active && wr_ready;
  assign bus_a_p    = pos[0];
  assign bus_a_n    = neg[0];
  assign bus_b_p    = pos[1];
  assign bus_b_n    = neg[1];
endmodule

// File: rtl/biphase_tx_chk.sv
module biphase_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic send_ready,
  input logic dis_a,
  input logic dis_b,
  input logic bus_a_p,
  input logic bus_a_n,
  input logic bus_b_p,
  input logic bus_b_n
);
  assert_pair_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_a_p || bus_a_n) |-> (bus_a_p != bus_a_n));
  assert_pair_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_b_p || bus_b_n) |-> (bus_b_p != bus_b_n));
  assert_one_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_a_p || bus_a_n) && (bus_b_p || bus_b_n)));
  assert_quiet_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dis_a |-> (!bus_a_p && !bus_a_n));
  assert_quiet_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dis_b |-> (!bus_b_p && !bus_b_n));
  assert_hold_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);
  assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    send_ready |-> wr_ready);
endmodule

bind biphase_tx biphase_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .send_ready(send_ready), .dis_a(dis_a), .dis_b(dis_b),
  .bus_a_p(bus_a_p), .bus_a_n(bus_a_n), .bus_b_p(bus_b_p), .bus_b_n(bus_b_n)
);

// File: tb/test_biphase_tx.sv
module test_biphase_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic        wr_chan_b = 1'b0;
  logic        wr_cmd_sync = 1'b0;
  logic        dis_a = 1'b0;
  logic        dis_b = 1'b0;
  logic        send_ready;
  logic        bus_a_p, bus_a_n, bus_b_p, bus_b_n;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  biphase_tx i_biphase_tx (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_chan_b(wr_chan_b), .wr_cmd_sync(wr_cmd_sync),
    .dis_a(dis_a), .dis_b(dis_b), .send_ready(send_ready),
    .bus_a_p(bus_a_p), .bus_a_n(bus_a_n), .bus_b_p(bus_b_p), .bus_b_n(bus_b_n)
  );

  // {chan_b, cmd_sync, data}
  localparam logic [17:0] VECS [5] = '{
    {1'b0, 1'b1, 16'hA5C3},
    {1'b1, 1'b0, 16'hFFFF},
    {1'b0, 1'b0, 16'h0000},
    {1'b1, 1'b1, 16'h8001},
    {1'b0, 1'b1, 16'h7FFE}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_word(input logic [15:0] d, input logic cmd);
    logic [39:0] w;
    for (int s = 0; s < 40; s++) begin
      if (s < 6) w[s] = (s < 3) ? cmd : ~cmd;
      else begin
        int  k;
        logic b;
        k = (s - 6) / 2;
        b = (k < 16) ? d[15-k] : ~^d;
        w[s] = ((s - 6) % 2 == 0) ? b : ~b;
      end
    end
    return w;
  endfunction

  task automatic put(input logic chan, input logic cmd, input logic [15:0] d);
    @(negedge clk);
    wr_chan_b = chan; wr_cmd_sync = cmd; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic grab(input int lead, input logic chan,
                      output logic [39:0] p, output logic [39:0] n,
                      output logic [39:0] o, output logic sr0);
    for (int s = 0; s < 40; s++) begin
      repeat ((s == 0) ? lead : 25) @(posedge clk);
      @(negedge clk);
      p[s] = chan ? bus_b_p : bus_a_p;
      n[s] = chan ? bus_b_n : bus_a_n;
      o[s] = chan ? (bus_a_p | bus_a_n) : (bus_b_p | bus_b_n);
      if (s == 0) sr0 = send_ready;
    end
  endtask

  task automatic check_word(input string tag, input logic [15:0] d, input logic cmd,
                            input logic [39:0] p, input logic [39:0] n, input logic [39:0] o);
    logic [39:0] e;
    e = exp_word(d, cmd);
    check(p == e, {tag, " R3/R4/R5 true output pattern"}, 64'(p), 64'(e));
    check(n == ~e, {tag, " R6 complement output"}, 64'(n), 64'(~e));
    check(o == '0, {tag, " R6 other pair idle"}, 64'(o), 64'd0);
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    check({bus_a_p, bus_a_n, bus_b_p, bus_b_n} == 4'b0, {tag, " R10 pairs idle"},
          64'({bus_a_p, bus_a_n, bus_b_p, bus_b_n}), 64'd0);
    check(send_ready == 1'b0, {tag, " R10 send_ready low"}, 64'(send_ready), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [39:0] p, n, o, p2, n2, o2, p3, n3, o3;
    logic        sr, sr2, sr3;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check({bus_a_p, bus_a_n, bus_b_p, bus_b_n} == 4'b0, "R1 outputs low in reset",
          64'({bus_a_p, bus_a_n, bus_b_p, bus_b_n}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_ready == 1'b1, "R1 wr_ready after reset", 64'(wr_ready), 64'd1);
    check(send_ready == 1'b0, "R1 send_ready after reset", 64'(send_ready), 64'd0);

    // Table of words walked by one loop
    for (int v = 0; v < 5; v++) begin
      put(VECS[v][17], VECS[v][16], VECS[v][15:0]);
      check({bus_a_p, bus_a_n, bus_b_p, bus_b_n} == 4'b0, "R2 no output on accept edge",
            64'({bus_a_p, bus_a_n, bus_b_p, bus_b_n}), 64'd0);
      @(posedge clk);
      grab(12, VECS[v][17], p, n, o, sr);
      check(sr == 1'b1, "R8 send_ready during word", 64'(sr), 64'd1);
      check_word("table", VECS[v][15:0], VECS[v][16], p, n, o);
      repeat (20) @(posedge clk);
      check_idle("table");
    end

    // Three words back to back; third write is back-pressured (R7, R8)
    put(1'b0, 1'b1, 16'h1234);
    @(posedge clk);
    fork
      begin
        grab(12, 1'b0, p, n, o, sr);
        grab(25, 1'b1, p2, n2, o2, sr2);
        grab(25, 1'b0, p3, n3, o3, sr3);
      end
      begin
        @(negedge clk);
        check(send_ready == 1'b1, "R8 window open", 64'(send_ready), 64'd1);
        put(1'b1, 1'b0, 16'hBEEF);
        check(wr_ready == 1'b0, "R7 wr_ready low while holding full", 64'(wr_ready), 64'd0);
        check(send_ready == 1'b0, "R8 window closed while holding full", 64'(send_ready), 64'd0);
        put(1'b0, 1'b0, 16'h0F0F);
      end
    join
    check_word("first", 16'h1234, 1'b1, p, n, o);
    check_word("second R8", 16'hBEEF, 1'b0, p2, n2, o2);
    check_word("third R7", 16'h0F0F, 1'b0, p3, n3, o3);
    repeat (20) @(posedge clk);
    check_idle("burst");

    // Disable of the selected pair (R9)
    dis_a = 1'b1;
    put(1'b0, 1'b1, 16'hC33C);
    @(posedge clk);
    grab(12, 1'b0, p, n, o, sr);
    check((p | n) == '0, "R9 disabled pair silent", 64'(p | n), 64'd0);
    check(sr == 1'b1, "R9 send_ready unaffected", 64'(sr), 64'd1);
    check(o == '0, "R9 other pair idle", 64'(o), 64'd0);
    repeat (20) @(posedge clk);
    check_idle("disabled");

    // Disable of the other pair has no effect (R9)
    dis_a = 1'b0; dis_b = 1'b1;
    put(1'b0, 1'b0, 16'h5A01);
    @(posedge clk);
    grab(12, 1'b0, p, n, o, sr);
    check_word("R9 other disabled", 16'h5A01, 1'b0, p, n, o);
    dis_b = 1'b0;
    repeat (20) @(posedge clk);
    check_idle("end");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule